// File: doc/BRIEF.md
# Extended-Precision Add Special-Case Resolver

This block sits beside the finite adder of a floating-point unit. It looks at the two operands of an addition, both in 80-bit extended layout (sign, 15-bit biased exponent, 64-bit significand with an explicit integer bit). For every pairing it either settles the sum on its own or reports that the general alignment-and-rounding path has to produce it. It settles NaNs, infinities, zeros and exact cancellation. When a result is settled here, it also reports whether the operation raised an invalid-operation exception.

Operand A is the destination, and A's NaN wins when both operands are NaN. Operand B may come from an integer converted to extended form. The `b_from_int` input marks this case, and an integer zero then counts as positive zero whatever sign bit it carries. The finite path reports back through `fin_zero` when two finite nonzero operands cancelled to exactly zero. The resolver then picks the sign of that zero from the rounding mode.

The inputs are sampled on a rising edge while `in_valid` is high. All outputs come from registers and appear one cycle later.

Top module: `fadd_special_resolver`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `out_valid`, `use_finite` and `invalid` are 0.
- R2: `out_valid` equals `in_valid` from the previous rising edge, and the result fields belong to the operands sampled at that edge.
- R3: Two infinities of equal sign give that infinity, with `invalid` 0. An infinity is exponent 7FFF hex with significand bits 62..0 all clear.
- R4: Two infinities of opposite sign set `invalid` and give the default quiet NaN: sign 1, exponent 7FFF, significand C000_0000_0000_0000 hex.
- R5: An infinity added to a zero or to a finite value returns the infinity operand unchanged, with both flags 0.
- R6: Two zeros of the same sign give a zero of that sign. A zero is exponent 0 and significand 0.
- R7: A zero sum formed from operands of opposite sign is +0 unless `rmode` is 01. The encodings are 00 nearest, 01 toward negative infinity, 10 toward positive infinity and 11 toward zero, and 01 gives -0. This covers a +0/-0 pair and also `fin_zero` with two finite nonzero operands of opposite sign.
- R8: With `b_from_int` high, a zero B is taken as +0 whatever `b_sign` is.
- R9: A zero added to a finite nonzero operand returns the finite operand unchanged, with `use_finite` 0.
- R10: Two finite nonzero operands with `fin_zero` low give `use_finite` 1, `invalid` 0 and all result fields 0.
- R11: If no operand is signalling, a quiet NaN operand is returned unchanged with `invalid` 0, and A's NaN is chosen when both are NaN. A NaN is exponent 7FFF with bits 62..0 nonzero, and it is quiet when bit 62 is set.
- R12: A signalling NaN operand (bit 62 clear) sets `invalid`. The returned NaN has bit 62 set and is otherwise unchanged, and A's NaN is still chosen when both are NaN.
- R13: `fin_zero` has no effect unless both operands are finite and nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands present this cycle |
| a_sign | input | 1 | Operand A sign |
| a_exp | input | 15 | Operand A biased exponent |
| a_sig | input | 64 | Operand A significand |
| b_sign | input | 1 | Operand B sign |
| b_exp | input | 15 | Operand B biased exponent |
| b_sig | input | 64 | Operand B significand |
| b_from_int | input | 1 | Operand B was converted from an integer |
| rmode | input | 2 | Rounding mode |
| fin_zero | input | 1 | Finite path produced an exact zero magnitude |
| out_valid | output | 1 | Result registered from last valid input |
| res_sign | output | 1 | Result sign |
| res_exp | output | 15 | Result exponent |
| res_sig | output | 64 | Result significand |
| use_finite | output | 1 | Result must come from the finite adder |
| invalid | output | 1 | Invalid-operation exception raised |

## Verification
The integer-zero override and the cancellation sign rule can act in the same cycle, when B is an integer zero with its sign bit set. The bench adds -0 to such a B under round-to-nearest, and +0 to it under round-toward-negative. Without the override the first case would give -0 and the second -0. With the override they must give +0 by the opposite-sign rule and +0 by the same-sign rule. The bench also holds `fin_zero` high alongside an infinity and a NaN, and checks that the flag has no effect there.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    parameter int EXP_W = 15;
    parameter int SIG_W = 64;
    localparam int QBIT = SIG_W - 2;

    typedef struct packed {
        logic             sign;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
    } xfp_t;

    typedef enum logic [2:0] {
        K_ZERO = 3'd0,
        K_FIN  = 3'd1,
        K_INF  = 3'd2,
        K_QNAN = 3'd3,
        K_SNAN = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic valid;
        xfp_t res;
        logic use_fin;
        logic inv;
    } state_t;
endpackage

// File: rtl/fsr_classify.sv
module fsr_classify
    import fsr_pkg::*;
(
    input  logic             op_sign,
    input  logic [EXP_W-1:0] op_exp,
    input  logic [SIG_W-1:0] op_sig,
    input  logic             from_int,
    output kind_e            kind,
    output xfp_t             val
);
    logic exp_max;
    logic exp_min;
    logic frac_zero;

    always_comb begin
        exp_max   = &op_exp;
        exp_min   = ~|op_exp;
        frac_zero = ~|op_sig[SIG_W-2:0];

        if (exp_max) begin
            if (frac_zero)          kind = K_INF;
            else if (op_sig[QBIT])  kind = K_QNAN;
            else                    kind = K_SNAN;
        end else if (exp_min && ~|op_sig) begin
            kind = K_ZERO;
        end else begin
            kind = K_FIN;
        end

        val.sign = op_sign;
        val.exp  = op_exp;
        val.sig  = op_sig;
        if (from_int && kind == K_ZERO) val.sign = 1'b0;
    end
endmodule

// File: rtl/fsr_decide.sv
module fsr_decide
    import fsr_pkg::*;
(
    input  kind_e      kind_a,
    input  kind_e      kind_b,
    input  xfp_t       val_a,
    input  xfp_t       val_b,
    input  logic [1:0] rmode,
    input  logic       fin_zero,
    output xfp_t       res,
    output logic       use_fin,
    output logic       inv
);
    logic nan_a, nan_b, snan_any;
    logic cancel_sign;
    xfp_t dflt_nan;

    always_comb begin
        nan_a       = (kind_a == K_QNAN) || (kind_a == K_SNAN);
        nan_b       = (kind_b == K_QNAN) || (kind_b == K_SNAN);
        snan_any    = (kind_a == K_SNAN) || (kind_b == K_SNAN);
        cancel_sign = (rmode_e'(rmode) == RM_DOWN);

        dflt_nan.sign = 1'b1;
        dflt_nan.exp  = '1;
        dflt_nan.sig  = '0;
        dflt_nan.sig[SIG_W-1] = 1'b1;
        dflt_nan.sig[QBIT]    = 1'b1;

        res     = '0;
        use_fin = 1'b0;
        inv     = 1'b0;

        if (nan_a || nan_b) begin
            inv = snan_any;
            res = nan_a ? val_a : val_b;
            res.sig[QBIT] = 1'b1;
        end else if (kind_a == K_INF && kind_b == K_INF) begin
            if (val_a.sign == val_b.sign) begin
                res = val_a;
            end else begin
                res = dflt_nan;
                inv = 1'b1;
            end
        end else if (kind_a == K_INF) begin
            res = val_a;
        end else if (kind_b == K_INF) begin
            res = val_b;
        end else if (kind_a == K_ZERO && kind_b == K_ZERO) begin
            res.sign = (val_a.sign == val_b.sign) ? val_a.sign : cancel_sign;
        end else if (kind_a == K_ZERO) begin
            res = val_b;
        end else if (kind_b == K_ZERO) begin
            res = val_a;
        end else if (fin_zero) begin
            res.sign = (val_a.sign == val_b.sign) ? val_a.sign : cancel_sign;
        end else begin
            use_fin = 1'b1;
        end
    end
endmodule

// File: rtl/fadd_special_resolver.sv
module fadd_special_resolver
    import fsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             a_sign,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic             b_sign,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    input  logic             b_from_int,
    input  logic [1:0]       rmode,
    input  logic             fin_zero,
    output logic             out_valid,
    output logic             res_sign,
    output logic [EXP_W-1:0] res_exp,
    output logic [SIG_W-1:0] res_sig,
    output logic             use_finite,
    output logic             invalid
);
    localparam int NOPS = 2;

    logic             op_sign [NOPS];
    logic [EXP_W-1:0] op_exp  [NOPS];
    logic [SIG_W-1:0] op_sig  [NOPS];
    logic             op_int  [NOPS];
    kind_e            op_kind [NOPS];
    xfp_t             op_val  [NOPS];

    always_comb begin
        op_sign[0] = a_sign;  op_exp[0] = a_exp;  op_sig[0] = a_sig;  op_int[0] = 1'b0;
        op_sign[1] = b_sign;  op_exp[1] = b_exp;  op_sig[1] = b_sig;  op_int[1] = b_from_int;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_cls
        fsr_classify u_cls (
            .op_sign  (op_sign[g]),
            .op_exp   (op_exp[g]),
            .op_sig   (op_sig[g]),
            .from_int (op_int[g]),
            .kind     (op_kind[g]),
            .val      (op_val[g])
        );
    end

    xfp_t dec_res;
    logic dec_fin;
    logic dec_inv;

    fsr_decide u_dec (
        .kind_a   (op_kind[0]),
        .kind_b   (op_kind[1]),
        .val_a    (op_val[0]),
        .val_b    (op_val[1]),
        .rmode    (rmode),
        .fin_zero (fin_zero),
        .res      (dec_res),
        .use_fin  (dec_fin),
        .inv      (dec_inv)
    );

    state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.res     = dec_res;
            st_d.use_fin = dec_fin;
            st_d.inv     = dec_inv;
        end else begin
            st_d.use_fin = 1'b0;
            st_d.inv     = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign res_sign   = st_q.res.sign;
    assign res_exp    = st_q.res.exp;
    assign res_sig    = st_q.res.sig;
    assign use_finite = st_q.use_fin;
    assign invalid    = st_q.inv;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             a_sign,
    input logic [EXP_W-1:0] a_exp,
    input logic [SIG_W-1:0] a_sig,
    input logic             b_sign,
    input logic [EXP_W-1:0] b_exp,
    input logic [SIG_W-1:0] b_sig,
    input logic             b_from_int,
    input logic [1:0]       rmode,
    input logic             fin_zero,
    input logic             out_valid,
    input logic             res_sign,
    input logic [EXP_W-1:0] res_exp,
    input logic [SIG_W-1:0] res_sig,
    input logic             use_finite,
    input logic             invalid
);
    logic a_inf, b_inf, a_snan;
    assign a_inf  = (&a_exp) && (a_sig[SIG_W-2:0] == '0);
    assign b_inf  = (&b_exp) && (b_sig[SIG_W-2:0] == '0);
    assign a_snan = (&a_exp) && !a_sig[QBIT] && (a_sig[SIG_W-2:0] != '0);

    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !use_finite && !invalid));

    p_same_inf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_inf && b_inf && a_sign == b_sign)
        |=> (!invalid && (&res_exp) && res_sign == $past(a_sign)));

    p_opp_inf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_inf && b_inf && a_sign != b_sign)
        |=> (invalid && res_sign && (&res_exp) && res_sig[SIG_W-1:SIG_W-2] == 2'b11));

    p_snan_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_snan) |=> (invalid && res_sig[QBIT] && !use_finite));

    p_flags_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        use_finite |-> !invalid);
endmodule

bind fadd_special_resolver fsr_checker u_chk (.*);

// File: tb/fadd_special_resolver_tb.sv
module fadd_special_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        a_sign = 1'b0, b_sign = 1'b0;
    logic [14:0] a_exp = '0, b_exp = '0;
    logic [63:0] a_sig = '0, b_sig = '0;
    logic        b_from_int = 1'b0;
    logic [1:0]  rmode = 2'b00;
    logic        fin_zero = 1'b0;
    logic        out_valid, res_sign, use_finite, invalid;
    logic [14:0] res_exp;
    logic [63:0] res_sig;

    int total = 0;
    int bad   = 0;

    localparam logic [14:0] EMAX  = 15'h7FFF;
    localparam logic [63:0] IBIT  = 64'h8000_0000_0000_0000;
    localparam logic [63:0] QNSIG = 64'hC000_0000_0000_0000;
    localparam logic [14:0] E1    = 15'h3FFF;
    localparam logic [63:0] M1    = 64'hA000_0000_0000_0000;

    fadd_special_resolver u_dut (.*);

    always #5 clk = ~clk;

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic got_s, input logic [14:0] got_e,
                       input logic [63:0] got_m, input logic got_f, input logic got_i,
                       input logic es, input logic [14:0] ee, input logic [63:0] em,
                       input logic ef, input logic ei);
        total++;
        if ({got_s, got_e, got_m, got_f, got_i} !== {es, ee, em, ef, ei}) begin
            bad++;
            $display("FAIL %s: actual s=%0b e=%h m=%h fin=%0b inv=%0b expected s=%0b e=%h m=%h fin=%0b inv=%0b",
                     tag, got_s, got_e, got_m, got_f, got_i, es, ee, em, ef, ei);
        end
    endtask

    // drive at negedge, pass one rising edge, sample at following negedge
    task automatic run(input string tag,
                       input logic as, input logic [14:0] ae, input logic [63:0] am,
                       input logic bs, input logic [14:0] be, input logic [63:0] bm,
                       input logic bint, input logic [1:0] rm, input logic fz,
                       input logic es, input logic [14:0] ee, input logic [63:0] em,
                       input logic ef, input logic ei);
        in_valid = 1'b1;
        a_sign = as; a_exp = ae; a_sig = am;
        b_sign = bs; b_exp = be; b_sig = bm;
        b_from_int = bint; rmode = rm; fin_zero = fz;
        @(negedge clk);
        total++;
        if (out_valid !== 1'b1) begin
            bad++;
            $display("FAIL R2 %s: out_valid actual %0b expected 1", tag, out_valid);
        end
        chk(tag, res_sign, res_exp, res_sig, use_finite, invalid, es, ee, em, ef, ei);
    endtask

    task automatic t_reset;
        total++;
        if ({out_valid, use_finite, invalid} !== 3'b000) begin
            bad++;
            $display("FAIL R1: flags actual %b expected 000", {out_valid, use_finite, invalid});
        end
    endtask

    task automatic t_idle;
        in_valid = 1'b0;
        @(negedge clk);
        total++;
        if ({out_valid, use_finite, invalid} !== 3'b000) begin
            bad++;
            $display("FAIL R2 idle: flags actual %b expected 000", {out_valid, use_finite, invalid});
        end
    endtask

    task automatic t_infinity;
        run("R3 +inf++inf", 0, EMAX, IBIT, 0, EMAX, IBIT, 0, 2'b00, 0, 0, EMAX, IBIT, 0, 0);
        run("R3 -inf+-inf", 1, EMAX, IBIT, 1, EMAX, IBIT, 0, 2'b01, 0, 1, EMAX, IBIT, 0, 0);
        run("R4 -inf++inf", 1, EMAX, IBIT, 0, EMAX, IBIT, 0, 2'b00, 0, 1, EMAX, QNSIG, 0, 1);
        run("R5 +inf+fin",  0, EMAX, IBIT, 1, E1, M1, 0, 2'b00, 0, 0, EMAX, IBIT, 0, 0);
        run("R5 zero+-inf", 0, 15'd0, 64'd0, 1, EMAX, IBIT, 0, 2'b10, 0, 1, EMAX, IBIT, 0, 0);
        run("R13 fin+inf fz", 0, E1, M1, 1, EMAX, IBIT, 0, 2'b01, 1, 1, EMAX, IBIT, 0, 0);
    endtask

    task automatic t_zeros;
        run("R6 +0++0", 0, 15'd0, 64'd0, 0, 15'd0, 64'd0, 0, 2'b01, 0, 0, 15'd0, 64'd0, 0, 0);
        run("R6 -0+-0", 1, 15'd0, 64'd0, 1, 15'd0, 64'd0, 0, 2'b00, 0, 1, 15'd0, 64'd0, 0, 0);
        run("R7 +0+-0 near", 0, 15'd0, 64'd0, 1, 15'd0, 64'd0, 0, 2'b00, 0, 0, 15'd0, 64'd0, 0, 0);
        run("R7 +0+-0 down", 0, 15'd0, 64'd0, 1, 15'd0, 64'd0, 0, 2'b01, 0, 1, 15'd0, 64'd0, 0, 0);
        run("R7 -0++0 up",   1, 15'd0, 64'd0, 0, 15'd0, 64'd0, 0, 2'b10, 0, 0, 15'd0, 64'd0, 0, 0);
        run("R7 -0++0 trunc",1, 15'd0, 64'd0, 0, 15'd0, 64'd0, 0, 2'b11, 0, 0, 15'd0, 64'd0, 0, 0);
    endtask

    task automatic t_int_zero;
        run("R8 -0+int-0 near", 1, 15'd0, 64'd0, 1, 15'd0, 64'd0, 1, 2'b00, 0, 0, 15'd0, 64'd0, 0, 0);
        run("R8 +0+int-0 down", 0, 15'd0, 64'd0, 1, 15'd0, 64'd0, 1, 2'b01, 0, 0, 15'd0, 64'd0, 0, 0);
    endtask

    task automatic t_finite;
        run("R9 0+fin",   0, 15'd0, 64'd0, 1, E1, M1, 0, 2'b00, 0, 1, E1, M1, 0, 0);
        run("R9 fin+-0",  0, 15'h4005, 64'hF123_4567_89AB_CDEF, 1, 15'd0, 64'd0, 0, 2'b01, 1,
            0, 15'h4005, 64'hF123_4567_89AB_CDEF, 0, 0);
        run("R10 fin+fin", 0, E1, M1, 0, 15'h4000, IBIT, 0, 2'b00, 0, 0, 15'd0, 64'd0, 1, 0);
        run("R7 cancel near", 0, E1, M1, 1, E1, M1, 0, 2'b00, 1, 0, 15'd0, 64'd0, 0, 0);
        run("R7 cancel down", 1, E1, M1, 0, E1, M1, 0, 2'b01, 1, 1, 15'd0, 64'd0, 0, 0);
    endtask

    task automatic t_nan;
        run("R11 qnanA+inf", 0, EMAX, 64'hC000_0000_0000_1234, 1, EMAX, IBIT, 0, 2'b00, 1,
            0, EMAX, 64'hC000_0000_0000_1234, 0, 0);
        run("R11 fin+qnanB", 0, E1, M1, 1, EMAX, 64'hE000_0000_0000_0000, 0, 2'b00, 0,
            1, EMAX, 64'hE000_0000_0000_0000, 0, 0);
        run("R11 qnanA+qnanB", 1, EMAX, 64'hC000_0000_0000_0001, 0, EMAX, 64'hC000_0000_0000_0002, 0, 2'b00, 0,
            1, EMAX, 64'hC000_0000_0000_0001, 0, 0);
        run("R12 fin+snanB", 0, E1, M1, 0, EMAX, 64'h8000_0000_0000_0055, 0, 2'b00, 0,
            0, EMAX, 64'hC000_0000_0000_0055, 0, 1);
        run("R12 snanA+qnanB", 1, EMAX, 64'h8000_0000_0000_0009, 0, EMAX, 64'hC000_0000_0000_0002, 0, 2'b00, 0,
            1, EMAX, 64'hC000_0000_0000_0009, 0, 1);
    endtask

    initial begin
        #1;
        t_reset;
        repeat (2) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_infinity;
        t_zeros;
        t_int_zero;
        t_finite;
        t_nan;
        t_idle;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule